// File: doc/BRIEF.md
# I2C Master Command Sequencer

This block sits between a queue of master commands and a byte-level I2C bit engine. It takes one command word at a time from the head of the command queue. It turns each word into a short series of bus actions: START, address byte, data byte, repeated START and STOP. Each command word carries one data byte and three flags: direction, STOP-after and RESTART-before. The sequencer therefore changes direction and ends a transfer one byte at a time, without any further software action.

Bytes read from the target are pushed into a receive queue as soon as the bit engine returns them. When the command queue runs dry in the middle of a transfer, the sequencer keeps ownership of the bus and waits. A NACK from the target, or a forbidden repeated START, ends the transfer: the sequencer sends STOP and discards the rest of the queued commands. Enable takes effect only between transfers, and an enable-status output tells software when the change has happened.

Top module: `i2c_cmd_seq`

## Requirements
- R1: A command word carries the data byte in bits 7:0, read (1) or write (0) in bit 8, STOP-after in bit 9 and RESTART-before in bit 10. A write command sends bits 7:0 as one data byte.
- R2: The first command of a transfer produces a START, then a write of the address byte. The address byte is the low 7 bits of `tgt_reg` in bits 7:1 and the command's read bit in bit 0. The upper bits of `tgt_reg` have no effect.
- R3: For a read command, bits 7:0 of the command have no effect. The sequencer requests a byte read and pushes the returned byte on `rxq_wdata` with `rxq_push` in the cycle `be_done` completes it. The master acknowledges each read byte, except a read that carries STOP-after, which it NACKs (`be_mnack`=1).
- R4: After a byte whose command has STOP-after set, a STOP is issued and the sequencer returns to idle.
- R5: With `restart_en`=1, a command that has RESTART-before set, or whose direction differs from the current address phase, is preceded by a repeated START and a new address byte.
- R6: When the command queue is empty after a byte without STOP-after, the sequencer issues no request, raises `bus_hold` and keeps `mst_active` high. It continues with the next command's data byte, without a new START.
- R7: A NACK on an address byte or a written data byte raises `tx_abort` for one cycle. The sequencer then issues a STOP, pops and discards every remaining command, and returns to idle. Nothing is pushed to the receive queue.
- R8: A command that needs a repeated START while `restart_en`=0 is discarded and handled as an abort, exactly as in R7.
- R9: `en_stat` takes the value of `en_req` only while the sequencer is idle. No command is popped while `en_stat` or `en_req` is 0.
- R10: Dropping `en_req` while the bus is held produces a STOP and a return to idle. A command that becomes available in the same cycle is left in the queue.
- R11: The bit engine request `be_req` stays high, with `be_op` and `be_wdata` unchanged, until `be_done`. The op codes are START=0, STOP=1, write byte=2 and read byte=3.
- R12: `mst_active` is 0 in reset and idle. It is 1 from the cycle after the first command is popped until the final STOP completes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en_req | input | 1 | Enable request |
| en_stat | output | 1 | Enable status, follows en_req between transfers |
| restart_en | input | 1 | Allow repeated START generation |
| tgt_reg | input | 10 | Target register, low 7 bits are the address |
| cmdq_empty | input | 1 | Command queue empty |
| cmdq_rdata | input | 11 | Command word at the queue head |
| cmdq_pop | output | 1 | Pop the command queue head |
| rxq_push | output | 1 | Push into receive queue |
| rxq_wdata | output | 8 | Received byte |
| be_req | output | 1 | Bit engine request |
| be_op | output | 2 | Bit engine operation |
| be_wdata | output | 8 | Byte to transmit |
| be_mnack | output | 1 | Master NACKs this read byte |
| be_done | input | 1 | Bit engine operation complete |
| be_nack | input | 1 | Target did not acknowledge a written byte |
| be_rdata | input | 8 | Byte read from the bus |
| tx_abort | output | 1 | Transmit abort event pulse |
| bus_hold | output | 1 | Bus held waiting for a command |
| mst_active | output | 1 | Master transfer in progress |

## Verification
While the bus is held, two things can land in the same cycle: a disable request and a newly available command. The bench pushes a command and drops `en_req` at the same clock edge. It then expects a STOP with no data byte, `en_stat` falling only after the STOP, and the command still waiting in the queue. A second collision is a command that needs a repeated START while repeated START is disabled. Here the pop of that command coincides with the abort decision. The bench expects the START, address and first byte, then a STOP and an empty queue.

// File: rtl/i2c_seq_pkg.sv
package i2c_seq_pkg;

  typedef enum logic [1:0] {
    BE_START = 2'd0,
    BE_STOP  = 2'd1,
    BE_WRITE = 2'd2,
    BE_READ  = 2'd3
  } be_op_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_START,
    ST_ADDR,
    ST_DATA,
    ST_HOLD,
    ST_STOP,
    ST_FLUSH
  } seq_state_e;

endpackage

// File: rtl/i2c_seq_en_ctrl.sv
module i2c_seq_en_ctrl (
  input  logic clk,
  input  logic rst_n,
  input  logic en_req,
  input  logic idle,
  output logic en_stat,
  output logic go
);

  logic stat_q;
  logic stat_d;
  logic stat_ce;

  assign stat_ce = idle;
  assign stat_d  = en_req;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stat_q <= 1'b0;
    end else if (stat_ce) begin
      stat_q <= stat_d;
    end
  end

  assign en_stat = stat_q;
  assign go      = stat_q & en_req;

endmodule

// File: rtl/i2c_seq_cmd_reg.sv
module i2c_seq_cmd_reg #(
  parameter  int DATA_W = 8,
  localparam int CMD_W  = DATA_W + 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [CMD_W-1:0]  cmd_in,
  input  logic              dir_upd,
  output logic [DATA_W-1:0] cur_data,
  output logic              cur_rd,
  output logic              cur_stop,
  output logic              in_needs_rs
);

  localparam int RD_BIT = DATA_W;
  localparam int SP_BIT = DATA_W + 1;
  localparam int RS_BIT = DATA_W + 2;

  logic [CMD_W-1:0] cmd_q;
  logic             dir_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd_q <= '0;
    end else if (load) begin
      cmd_q <= cmd_in;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dir_q <= 1'b0;
    end else if (dir_upd) begin
      dir_q <= cmd_q[RD_BIT];
    end
  end

  assign cur_data    = cmd_q[DATA_W-1:0];
  assign cur_rd      = cmd_q[RD_BIT];
  assign cur_stop    = cmd_q[SP_BIT];
  assign in_needs_rs = cmd_in[RS_BIT] | (cmd_in[RD_BIT] != dir_q);

endmodule

// File: rtl/i2c_seq_fsm.sv
module i2c_seq_fsm
  import i2c_seq_pkg::*;
#(
  parameter  int DATA_W = 8,
  localparam int ADDR_W = DATA_W - 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              go,
  input  logic              en_req,
  input  logic              restart_en,
  input  logic [ADDR_W-1:0] tgt_addr,
  input  logic              cmdq_empty,
  input  logic [DATA_W-1:0] cur_data,
  input  logic              cur_rd,
  input  logic              cur_stop,
  input  logic              in_needs_rs,
  input  logic              be_done,
  input  logic              be_nack,
  input  logic [DATA_W-1:0] be_rdata,
  output logic              cmdq_pop,
  output logic              load,
  output logic              dir_upd,
  output logic              be_req,
  output logic [1:0]        be_op,
  output logic [DATA_W-1:0] be_wdata,
  output logic              be_mnack,
  output logic              rxq_push,
  output logic [DATA_W-1:0] rxq_wdata,
  output logic              tx_abort,
  output logic              bus_hold,
  output logic              mst_active,
  output logic              idle
);

  seq_state_e state_q, state_d;
  logic       pend_q, pend_d;

  // next-state logic
  always_comb begin
    state_d  = state_q;
    pend_d   = pend_q;
    cmdq_pop = 1'b0;
    load     = 1'b0;
    dir_upd  = 1'b0;
    rxq_push = 1'b0;
    tx_abort = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (go && !cmdq_empty) begin
          cmdq_pop = 1'b1;
          load     = 1'b1;
          state_d  = ST_START;
        end
      end
      ST_START: begin
        if (be_done) state_d = ST_ADDR;
      end
      ST_ADDR: begin
        if (be_done) begin
          if (be_nack) begin
            tx_abort = 1'b1;
            pend_d   = 1'b1;
            state_d  = ST_STOP;
          end else begin
            dir_upd = 1'b1;
            state_d = ST_DATA;
          end
        end
      end
      ST_DATA: begin
        if (be_done) begin
          if (!cur_rd && be_nack) begin
            tx_abort = 1'b1;
            pend_d   = 1'b1;
            state_d  = ST_STOP;
          end else begin
            rxq_push = cur_rd;
            state_d  = cur_stop ? ST_STOP : ST_HOLD;
          end
        end
      end
      ST_HOLD: begin
        if (!en_req) begin
          state_d = ST_STOP;
        end else if (!cmdq_empty) begin
          cmdq_pop = 1'b1;
          load     = 1'b1;
          if (!in_needs_rs) begin
            state_d = ST_DATA;
          end else if (restart_en) begin
            state_d = ST_START;
          end else begin
            tx_abort = 1'b1;
            pend_d   = 1'b1;
            state_d  = ST_STOP;
          end
        end
      end
      ST_STOP: begin
        if (be_done) state_d = pend_q ? ST_FLUSH : ST_IDLE;
      end
      ST_FLUSH: begin
        if (!cmdq_empty) begin
          cmdq_pop = 1'b1;
        end else begin
          pend_d  = 1'b0;
          state_d = ST_IDLE;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  // state registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      pend_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      pend_q  <= pend_d;
    end
  end

  // bit engine request decode
  always_comb begin
    be_req   = 1'b0;
    be_op    = BE_START;
    be_wdata = '0;
    be_mnack = 1'b0;
    unique case (state_q)
      ST_START: begin
        be_req = 1'b1;
        be_op  = BE_START;
      end
      ST_ADDR: begin
        be_req   = 1'b1;
        be_op    = BE_WRITE;
        be_wdata = {tgt_addr, cur_rd};
      end
      ST_DATA: begin
        be_req   = 1'b1;
        be_op    = cur_rd ? BE_READ : BE_WRITE;
        be_wdata = cur_rd ? '0 : cur_data;
        be_mnack = cur_rd & cur_stop;
      end
      ST_STOP: begin
        be_req = 1'b1;
        be_op  = BE_STOP;
      end
      default: ;
    endcase
  end

  assign rxq_wdata  = be_rdata;
  assign bus_hold   = (state_q == ST_HOLD);
  assign mst_active = (state_q != ST_IDLE);
  assign idle       = (state_q == ST_IDLE);

endmodule

// File: rtl/i2c_cmd_seq.sv
module i2c_cmd_seq #(
  parameter  int DATA_W = 8,
  parameter  int TGT_W  = 10,
  localparam int ADDR_W = DATA_W - 1,
  localparam int CMD_W  = DATA_W + 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en_req,
  output logic              en_stat,
  input  logic              restart_en,
  input  logic [TGT_W-1:0]  tgt_reg,
  input  logic              cmdq_empty,
  input  logic [CMD_W-1:0]  cmdq_rdata,
  output logic              cmdq_pop,
  output logic              rxq_push,
  output logic [DATA_W-1:0] rxq_wdata,
  output logic              be_req,
  output logic [1:0]        be_op,
  output logic [DATA_W-1:0] be_wdata,
  output logic              be_mnack,
  input  logic              be_done,
  input  logic              be_nack,
  input  logic [DATA_W-1:0] be_rdata,
  output logic              tx_abort,
  output logic              bus_hold,
  output logic              mst_active
);

  logic              go;
  logic              idle;
  logic              load;
  logic              dir_upd;
  logic [DATA_W-1:0] cur_data;
  logic              cur_rd;
  logic              cur_stop;
  logic              in_needs_rs;

  i2c_seq_en_ctrl u_en (
    .clk     (clk),
    .rst_n   (rst_n),
    .en_req  (en_req),
    .idle    (idle),
    .en_stat (en_stat),
    .go      (go)
  );

  i2c_seq_cmd_reg #(.DATA_W(DATA_W)) u_cmd (
    .clk         (clk),
    .rst_n       (rst_n),
    .load        (load),
    .cmd_in      (cmdq_rdata),
    .dir_upd     (dir_upd),
    .cur_data    (cur_data),
    .cur_rd      (cur_rd),
    .cur_stop    (cur_stop),
    .in_needs_rs (in_needs_rs)
  );

  i2c_seq_fsm #(.DATA_W(DATA_W)) u_fsm (
    .clk         (clk),
    .rst_n       (rst_n),
    .go          (go),
    .en_req      (en_req),
    .restart_en  (restart_en),
    .tgt_addr    (tgt_reg[ADDR_W-1:0]),
    .cmdq_empty  (cmdq_empty),
    .cur_data    (cur_data),
    .cur_rd      (cur_rd),
    .cur_stop    (cur_stop),
    .in_needs_rs (in_needs_rs),
    .be_done     (be_done),
    .be_nack     (be_nack),
    .be_rdata    (be_rdata),
    .cmdq_pop    (cmdq_pop),
    .load        (load),
    .dir_upd     (dir_upd),
    .be_req      (be_req),
    .be_op       (be_op),
    .be_wdata    (be_wdata),
    .be_mnack    (be_mnack),
    .rxq_push    (rxq_push),
    .rxq_wdata   (rxq_wdata),
    .tx_abort    (tx_abort),
    .bus_hold    (bus_hold),
    .mst_active  (mst_active),
    .idle        (idle)
  );

endmodule

// File: rtl/i2c_cmd_seq_chk.sv
module i2c_cmd_seq_chk #(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              en_stat,
  input logic              mst_active,
  input logic              cmdq_empty,
  input logic              cmdq_pop,
  input logic              rxq_push,
  input logic              be_req,
  input logic [1:0]        be_op,
  input logic [DATA_W-1:0] be_wdata,
  input logic              be_done,
  input logic              tx_abort,
  input logic              bus_hold
);

  AST_REQ_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (be_req && !be_done) |=> (be_req && $stable(be_op) && $stable(be_wdata))); // R11

  AST_PUSH_ON_READ: assert property (@(posedge clk) disable iff (!rst_n)
    rxq_push |-> (be_done && be_op == 2'd3)); // R3

  AST_ABORT_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    tx_abort |=> !tx_abort); // R7

  AST_POP_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    cmdq_pop |-> (!cmdq_empty && en_stat)); // R9

  AST_HOLD_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    bus_hold |-> (!be_req && mst_active)); // R6

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !mst_active |-> !be_req); // R12

  AST_ENSTAT_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (en_stat != $past(en_stat)) |-> !$past(mst_active)); // R9

endmodule

bind i2c_cmd_seq i2c_cmd_seq_chk #(.DATA_W(DATA_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .en_stat    (en_stat),
  .mst_active (mst_active),
  .cmdq_empty (cmdq_empty),
  .cmdq_pop   (cmdq_pop),
  .rxq_push   (rxq_push),
  .be_req     (be_req),
  .be_op      (be_op),
  .be_wdata   (be_wdata),
  .be_done    (be_done),
  .tx_abort   (tx_abort),
  .bus_hold   (bus_hold)
);

// File: tb/i2c_cmd_seq_test.sv
module i2c_cmd_seq_test;

  localparam int CLK_PERIOD = 10;
  localparam int LAT        = 3;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        en_req = 1'b0;
  logic        en_stat;
  logic        restart_en = 1'b1;
  logic [9:0]  tgt_reg = 10'h3A5;   // low 7 bits 0x25: write addr 0x4A, read addr 0x4B
  logic        cmdq_empty;
  logic [10:0] cmdq_rdata;
  logic        cmdq_pop;
  logic        rxq_push;
  logic [7:0]  rxq_wdata;
  logic        be_req;
  logic [1:0]  be_op;
  logic [7:0]  be_wdata;
  logic        be_mnack;
  logic        be_done = 1'b0;
  logic        be_nack = 1'b0;
  logic [7:0]  be_rdata = 8'h00;
  logic        tx_abort;
  logic        bus_hold;
  logic        mst_active;

  always #(CLK_PERIOD/2) clk = ~clk;

  i2c_cmd_seq uut (
    .clk(clk), .rst_n(rst_n), .en_req(en_req), .en_stat(en_stat),
    .restart_en(restart_en), .tgt_reg(tgt_reg), .cmdq_empty(cmdq_empty),
    .cmdq_rdata(cmdq_rdata), .cmdq_pop(cmdq_pop), .rxq_push(rxq_push),
    .rxq_wdata(rxq_wdata), .be_req(be_req), .be_op(be_op), .be_wdata(be_wdata),
    .be_mnack(be_mnack), .be_done(be_done), .be_nack(be_nack), .be_rdata(be_rdata),
    .tx_abort(tx_abort), .bus_hold(bus_hold), .mst_active(mst_active)
  );

  // command queue model
  logic [10:0] cq [0:63];
  logic [5:0]  head = 6'd0;
  logic [5:0]  tail = 6'd0;
  assign cmdq_empty = (head == tail);
  assign cmdq_rdata = cq[head];
  always @(posedge clk) if (cmdq_pop) head <= head + 6'd1;

  // bit engine model and logs
  logic [10:0] oplog [0:255];
  logic [7:0]  rxlog [0:255];
  int log_n = 0, rx_n = 0, ab_n = 0, wcnt = 0, nack_at = -1;

  always @(posedge clk) begin
    if (be_done) begin
      be_done <= 1'b0;
      be_nack <= 1'b0;
    end else if (be_req) begin
      if (wcnt == LAT) begin
        wcnt     <= 0;
        be_done  <= 1'b1;
        be_nack  <= (log_n == nack_at);
        be_rdata <= 8'h5A ^ log_n[7:0];
        oplog[log_n] <= {be_op, (be_op == 2'd3) ? be_mnack : 1'b0,
                         (be_op == 2'd2) ? be_wdata : 8'h00};
        log_n <= log_n + 1;
      end else begin
        wcnt <= wcnt + 1;
      end
    end
  end

  always @(posedge clk) begin
    if (rxq_push) begin
      rxlog[rx_n] <= rxq_wdata;
      rx_n <= rx_n + 1;
    end
    if (tx_abort) ab_n <= ab_n + 1;
  end

  int checks = 0, errors = 0;
  int base, rbase, abase, ex_n;
  logic [10:0] ex [0:15];

  localparam logic [10:0] E_START = 11'h000;
  localparam logic [10:0] E_STOP  = 11'h200;
  function automatic logic [10:0] e_wr(input logic [7:0] d); return {2'd2, 1'b0, d}; endfunction
  function automatic logic [10:0] e_rd(input logic mn); return {2'd3, mn, 8'h00}; endfunction

  task automatic chk(input logic c, input string tag, input int act, input int expv);
    checks++;
    if (!c) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", tag, act, expv);
    end
  endtask

  task automatic push(input logic [10:0] c);
    cq[tail] = c;
    tail = tail + 6'd1;
  endtask

  task automatic begin_case();
    base = log_n; rbase = rx_n; abase = ab_n; ex_n = 0;
  endtask

  task automatic ex_add(input logic [10:0] e);
    ex[ex_n] = e;
    ex_n++;
  endtask

  task automatic wait_idle();
    repeat (2) @(negedge clk);
    for (int i = 0; i < 3000 && mst_active; i++) @(negedge clk);
  endtask

  task automatic cmp_log(input string tag);
    chk(log_n - base == ex_n, {tag, " op count"}, log_n - base, ex_n);
    for (int i = 0; i < ex_n; i++)
      chk(oplog[base+i] == ex[i], {tag, " op"}, oplog[base+i], ex[i]);
  endtask

  task automatic t_reset();
    chk(en_stat == 0 && be_req == 0 && cmdq_pop == 0, "R9 reset outputs", {en_stat, be_req, cmdq_pop}, 0);
    chk(mst_active == 0 && bus_hold == 0, "R12 reset idle", {mst_active, bus_hold}, 0);
  endtask

  task automatic t_enable();
    begin_case();
    push(11'h211);
    repeat (30) @(negedge clk);
    chk(tail - head == 6'd1, "R9 no pop while disabled", int'(tail - head), 1);
    chk(be_req == 0 && en_stat == 0, "R9 disabled quiet", {be_req, en_stat}, 0);
    en_req = 1'b1;
    @(negedge clk);
    chk(en_stat == 1, "R9 en_stat follows", en_stat, 1);
    wait_idle();
    ex_add(E_START); ex_add(e_wr(8'h4A)); ex_add(e_wr(8'h11)); ex_add(E_STOP);
    cmp_log("R2 R4 enable then write");
  endtask

  task automatic t_write();
    begin_case();
    push(11'h011); push(11'h222);
    wait_idle();
    ex_add(E_START); ex_add(e_wr(8'h4A)); ex_add(e_wr(8'h11)); ex_add(e_wr(8'h22)); ex_add(E_STOP);
    cmp_log("R1 R2 R4 two writes");
    chk(mst_active == 0 && cmdq_empty, "R12 idle after stop", mst_active, 0);
  endtask

  task automatic t_read();
    begin_case();
    push(11'h1FF); push(11'h3C3);
    wait_idle();
    ex_add(E_START); ex_add(e_wr(8'h4B)); ex_add(e_rd(1'b0)); ex_add(e_rd(1'b1)); ex_add(E_STOP);
    cmp_log("R3 read ops");
    chk(rx_n - rbase == 2, "R3 rx count", rx_n - rbase, 2);
    chk(rxlog[rbase] == (8'h5A ^ 8'(base + 2)), "R3 rx byte0", rxlog[rbase], 8'h5A ^ 8'(base + 2));
    chk(rxlog[rbase+1] == (8'h5A ^ 8'(base + 3)), "R3 rx byte1", rxlog[rbase+1], 8'h5A ^ 8'(base + 3));
  endtask

  task automatic t_dir_change();
    begin_case();
    push(11'h033); push(11'h300);
    wait_idle();
    ex_add(E_START); ex_add(e_wr(8'h4A)); ex_add(e_wr(8'h33));
    ex_add(E_START); ex_add(e_wr(8'h4B)); ex_add(e_rd(1'b1)); ex_add(E_STOP);
    cmp_log("R5 direction change");
  endtask

  task automatic t_restart_flag();
    begin_case();
    push(11'h044); push(11'h655);
    wait_idle();
    ex_add(E_START); ex_add(e_wr(8'h4A)); ex_add(e_wr(8'h44));
    ex_add(E_START); ex_add(e_wr(8'h4A)); ex_add(e_wr(8'h55)); ex_add(E_STOP);
    cmp_log("R5 explicit restart");
  endtask

  task automatic t_hold();
    begin_case();
    push(11'h066);
    repeat (40) @(negedge clk);
    chk(bus_hold == 1 && mst_active == 1 && be_req == 0, "R6 holding", {bus_hold, mst_active, be_req}, 3'b110);
    chk(log_n - base == 3, "R6 ops before hold", log_n - base, 3);
    push(11'h277);
    wait_idle();
    ex_add(E_START); ex_add(e_wr(8'h4A)); ex_add(e_wr(8'h66)); ex_add(e_wr(8'h77)); ex_add(E_STOP);
    cmp_log("R6 continue after hold");
  endtask

  task automatic t_nack();
    begin_case();
    nack_at = base + 1;
    push(11'h088); push(11'h099); push(11'h2AA);
    wait_idle();
    nack_at = -1;
    ex_add(E_START); ex_add(e_wr(8'h4A)); ex_add(E_STOP);
    cmp_log("R7 address nack");
    chk(ab_n - abase == 1, "R7 abort pulses", ab_n - abase, 1);
    chk(cmdq_empty == 1, "R7 queue flushed", cmdq_empty, 1);
    chk(rx_n == rbase, "R7 no rx push", rx_n - rbase, 0);
  endtask

  task automatic t_rs_disabled();
    begin_case();
    restart_en = 1'b0;
    push(11'h0BB); push(11'h1CC); push(11'h2DD);
    wait_idle();
    restart_en = 1'b1;
    ex_add(E_START); ex_add(e_wr(8'h4A)); ex_add(e_wr(8'hBB)); ex_add(E_STOP);
    cmp_log("R8 restart disabled");
    chk(ab_n - abase == 1, "R8 abort pulse", ab_n - abase, 1);
    chk(cmdq_empty == 1, "R8 queue flushed", cmdq_empty, 1);
  endtask

  task automatic t_disable_hold();
    begin_case();
    push(11'h0EE);
    repeat (40) @(negedge clk);
    push(11'h2FF);
    en_req = 1'b0;
    repeat (2) @(negedge clk);
    chk(en_stat == 1 && mst_active == 1, "R9 en_stat waits for idle", {en_stat, mst_active}, 3);
    wait_idle();
    @(negedge clk);
    chk(en_stat == 0, "R10 disabled after stop", en_stat, 0);
    chk(tail - head == 6'd1, "R10 command left queued", int'(tail - head), 1);
    ex_add(E_START); ex_add(e_wr(8'h4A)); ex_add(e_wr(8'hEE)); ex_add(E_STOP);
    cmp_log("R10 disable in hold");
    begin_case();
    en_req = 1'b1;
    wait_idle();
    ex_add(E_START); ex_add(e_wr(8'h4A)); ex_add(e_wr(8'hFF)); ex_add(E_STOP);
    cmp_log("R10 R11 resumed after enable");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_enable();
    t_write();
    t_read();
    t_dir_change();
    t_restart_flag();
    t_hold();
    t_nack();
    t_rs_disabled();
    t_disable_hold();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog actual 1 expected 0");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule